// File: doc/BRIEF.md
# Fast A20 Gate and Software CPU Reset Register

This block is a single 8-bit control register on a small host I/O bus, decoded at one configurable address (0x92 by default). It gives software a quick way to force the A20 address line on and to reset the CPU, without the slow path through the keyboard controller. Bit 1 of the register drives an alternate A20 level. Bit 0 requests a CPU reset. A rising request starts a down-counter sequencer. The sequencer waits a programmable delay, then drives a low pulse of programmable width on an active-low alternate reset line.

The block merges its outputs with the keyboard controller's own signals. The A20 output is the OR of the controller's gate-A20 and register bit 1. The alternate reset is ANDed with the controller's active-low reset. A configuration input then picks the polarity of that combined reset. An external enable bit, taken from a configuration register, gates every bus access and every new pulse. All outputs are registered.

Top module: `fast_a20_reset_reg`

## Requirements
- R1: After synchronous reset the register reads 0x24, `alt_rst_n` is 1, and `a20_out` follows `kbc_gate_a20` alone (bit 1 is 0).
- R2: While `port_en` is 0, writes do not change bits 1:0 and start no pulse, and reads return 0x00.
- R3: A valid read returns 0x24 OR'd with bits 1:0 in positions 1:0. Bits 7:2 always read 0b001001, whatever was written. The data appears on `bus_rdata` one clock after the read edge. Otherwise `bus_rdata` is 0x00.
- R4: `a20_out` equals the OR of `kbc_gate_a20` and register bit 1, as sampled one clock earlier.
- R5: A write that takes bit 0 from 0 to 1 drives `alt_rst_n` low exactly DELAY_CYC+1 clocks after the write edge.
- R6: The low pulse lasts exactly PULSE_CYC clocks. `alt_rst_n` then stays high for as long as bit 0 stays 1.
- R7: Writing 1 to bit 0 while it is already 1 starts no new pulse.
- R8: A write that clears bit 0 during the delay or the pulse aborts the sequence. `alt_rst_n` is high by the next clock. A later 0-to-1 write restarts the full delay.
- R9: `sys_rst_out` is (`alt_rst_n` AND `kbc_rst_n`) one clock later when `rst_polarity` is 0, and its inverse when `rst_polarity` is 1.
- R10: Accesses to any address other than REG_ADDR have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| port_en | input | 1 | Register enable from configuration |
| kbc_gate_a20 | input | 1 | Keyboard controller gate-A20 |
| kbc_rst_n | input | 1 | Keyboard controller reset, active low |
| rst_polarity | input | 1 | 0: combined reset active low, 1: active high |
| alt_rst_n | output | 1 | Alternate CPU reset pulse, active low |
| a20_out | output | 1 | Combined A20 enable |
| sys_rst_out | output | 1 | Combined CPU reset with selected polarity |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the register bits change only through the bus decode. The bound checker compares outputs with inputs and register bits sampled one clock earlier. It arms only after a full clock out of reset, so the reset values of the registered outputs are never checked against pre-reset inputs.

The stimulus drives every input on the falling edge and holds it for a whole cycle. Strobes last one cycle. `port_en`, `rst_polarity` and the keyboard controller signals change only between bus transactions.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam logic [7:0] REG_FIXED = 8'h24;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_LOW  = 2'd2,
    SEQ_HOLD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/a20_ctl_regs.sv
module a20_ctl_regs
  import a20_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h92
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              port_en,
  output logic [7:0]        bus_rdata,
  output logic [1:0]        ctl_bits
);
  logic hit;
  assign hit = port_en && (bus_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_bits  <= 2'b00;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_wr && hit) ctl_bits <= bus_wdata[1:0];
      bus_rdata <= (bus_rd && hit) ? (REG_FIXED | {6'b0, ctl_bits}) : 8'h00;
    end
  end
endmodule

// File: rtl/a20_pulse_seq.sv
module a20_pulse_seq
  import a20_pkg::*;
#(
  parameter int DELAY_CYC = 700,
  parameter int PULSE_CYC = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic alt_rst_n
);
  localparam int MAXC  = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PLS_LOAD = CNT_W'(PULSE_CYC - 1);

  seq_state_t       state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (!req) begin
      state_nx = SEQ_IDLE;
      cnt_nx   = '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          state_nx = SEQ_WAIT;
          cnt_nx   = DLY_LOAD;
        end
        SEQ_WAIT: begin
          if (cnt == '0) begin
            state_nx = SEQ_LOW;
            cnt_nx   = PLS_LOAD;
          end else begin
            cnt_nx = cnt - 1'b1;
          end
        end
        SEQ_LOW: begin
          if (cnt == '0) state_nx = SEQ_HOLD;
          else           cnt_nx   = cnt - 1'b1;
        end
        default: state_nx = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      cnt       <= '0;
      alt_rst_n <= 1'b1;
    end else begin
      state     <= state_nx;
      cnt       <= cnt_nx;
      alt_rst_n <= (state_nx != SEQ_LOW);
    end
  end
endmodule

// File: rtl/a20_out_merge.sv
module a20_out_merge (
  input  logic clk,
  input  logic rst,
  input  logic alt_rst_n,
  input  logic kbc_rst_n,
  input  logic kbc_gate_a20,
  input  logic alt_a20,
  input  logic rst_polarity,
  output logic a20_out,
  output logic sys_rst_out
);
  logic rst_and_n;
  assign rst_and_n = alt_rst_n & kbc_rst_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      a20_out     <= 1'b0;
      sys_rst_out <= ~rst_polarity;
    end else begin
      a20_out     <= kbc_gate_a20 | alt_a20;
      sys_rst_out <= rst_polarity ? ~rst_and_n : rst_and_n;
    end
  end
endmodule

// File: rtl/fast_a20_reset_reg.sv
module fast_a20_reset_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h92,
  parameter int DELAY_CYC = 700,
  parameter int PULSE_CYC = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              port_en,
  input  logic              kbc_gate_a20,
  input  logic              kbc_rst_n,
  input  logic              rst_polarity,
  output logic              alt_rst_n,
  output logic              a20_out,
  output logic              sys_rst_out
);
  logic [1:0] ctl_bits;

  a20_ctl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .port_en(port_en),
    .bus_rdata(bus_rdata), .ctl_bits(ctl_bits)
  );

  a20_pulse_seq #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC)) u_seq (
    .clk(clk), .rst(rst), .req(ctl_bits[0]), .alt_rst_n(alt_rst_n)
  );

  a20_out_merge u_merge (
    .clk(clk), .rst(rst), .alt_rst_n(alt_rst_n), .kbc_rst_n(kbc_rst_n),
    .kbc_gate_a20(kbc_gate_a20), .alt_a20(ctl_bits[1]),
    .rst_polarity(rst_polarity), .a20_out(a20_out), .sys_rst_out(sys_rst_out)
  );
endmodule

// File: rtl/a20_port_chk.sv
module a20_port_chk #(
  parameter int PULSE_CYC = 300
) (
  input logic       clk,
  input logic       rst,
  input logic       port_en,
  input logic       kbc_gate_a20,
  input logic       kbc_rst_n,
  input logic       rst_polarity,
  input logic       alt_rst_n,
  input logic       a20_out,
  input logic       sys_rst_out,
  input logic [1:0] ctl_bits
);
  logic        seen;
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      low_cnt <= '0;
    end else begin
      seen    <= 1'b1;
      low_cnt <= alt_rst_n ? '0 : low_cnt + 1;
    end
  end

  // R4: A20 output is the OR of its sources one clock earlier
  p_a20_or_r4: assert property (@(posedge clk) disable iff (rst)
    seen |-> a20_out == ($past(kbc_gate_a20) | $past(ctl_bits[1])));

  // R9: combined reset with selected polarity
  p_combine_r9: assert property (@(posedge clk) disable iff (rst)
    seen |-> sys_rst_out == ($past(rst_polarity) ^ ($past(alt_rst_n) & $past(kbc_rst_n))));

  // R8: a cleared request forces the reset line high
  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(ctl_bits[0])) |-> alt_rst_n);

  // R2: register bits hold while disabled
  p_dis_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(port_en)) |-> ctl_bits == $past(ctl_bits));

  // R6: pulse never longer than the configured width
  p_width_r6: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= PULSE_CYC);

  // R5: a pulse only begins while a request is held
  p_req_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && $fell(alt_rst_n)) |-> $past(ctl_bits[0]));
endmodule

bind fast_a20_reset_reg a20_port_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst(rst), .port_en(port_en), .kbc_gate_a20(kbc_gate_a20),
  .kbc_rst_n(kbc_rst_n), .rst_polarity(rst_polarity), .alt_rst_n(alt_rst_n),
  .a20_out(a20_out), .sys_rst_out(sys_rst_out), .ctl_bits(ctl_bits)
);

// File: tb/fast_a20_reset_reg_tb.sv
module fast_a20_reset_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 20;
  localparam int P = 8;
  localparam logic [15:0] A = 16'h0092;

  logic        clk = 0, rst = 1;
  logic [15:0] bus_addr = A;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        port_en = 1, kbc_gate_a20 = 0, kbc_rst_n = 1, rst_polarity = 0;
  logic        alt_rst_n, a20_out, sys_rst_out;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_a20_reset_reg #(.ADDR_W(16), .REG_ADDR(A), .DELAY_CYC(D), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_en(port_en),
    .kbc_gate_a20(kbc_gate_a20), .kbc_rst_n(kbc_rst_n), .rst_polarity(rst_polarity),
    .alt_rst_n(alt_rst_n), .a20_out(a20_out), .sys_rst_out(sys_rst_out)
  );

  // {wdata, port_en, kbc_gate_a20, expected read, expected a20}
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {8'hFE, 1'b1, 1'b0, 8'h26, 1'b1},
    {8'h00, 1'b1, 1'b0, 8'h24, 1'b0},
    {8'h00, 1'b1, 1'b1, 8'h24, 1'b1},
    {8'h02, 1'b0, 1'b0, 8'h24, 1'b0},
    {8'hDA, 1'b1, 1'b0, 8'h26, 1'b1},
    {8'h00, 1'b0, 1'b0, 8'h26, 1'b1},
    {8'h00, 1'b1, 1'b0, 8'h24, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_addr = A;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges from the write until alt_rst_n goes low, then the low width
  task automatic measure(output int dly, output int wid);
    dly = 0; wid = 0;
    while (alt_rst_n && dly < 500) begin @(negedge clk); dly++; end
    while (!alt_rst_n && wid < 500) begin wid++; @(negedge clk); end
  endtask

  logic [7:0] rv;
  bit         all_high;
  int         dly, wid;

  initial begin
    cycles(3);
    rst = 0;
    @(negedge clk);
    rd(rv);
    check("R1 reset read", rv, 8'h24);
    check("R1 alt_rst_n", alt_rst_n, 1);
    check("R1 a20_out", a20_out, 0);
    check("R9 reset sys_rst_out", sys_rst_out, 1);

    for (int i = 0; i < NV; i++) begin
      port_en = VEC[i][10];
      kbc_gate_a20 = VEC[i][9];
      wr(A, VEC[i][18:11]);
      port_en = 1;
      rd(rv);
      check("R2/R3 table read", rv, VEC[i][8:1]);
      @(negedge clk);
      check("R4 table a20", a20_out, VEC[i][0]);
    end
    kbc_gate_a20 = 0;

    port_en = 0;
    rd(rv);
    check("R2 disabled read", rv, 8'h00);
    port_en = 1;

    wr(16'h0093, 8'h02);
    rd(rv);
    check("R10 other address", rv, 8'h24);
    cycles(1);
    check("R10 a20 unchanged", a20_out, 0);

    wr(A, 8'h01);
    measure(dly, wid);
    check("R5 delay", dly, D + 1);
    check("R6 width", wid, P);
    all_high = 1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!alt_rst_n) all_high = 0; end
    check("R6 stays high", all_high, 1);

    wr(A, 8'h01);
    all_high = 1;
    for (int i = 0; i < D + P + 10; i++) begin @(negedge clk); if (!alt_rst_n) all_high = 0; end
    check("R7 no re-trigger", all_high, 1);
    rd(rv);
    check("R7 read back", rv, 8'h25);

    wr(A, 8'h00);
    wr(A, 8'h01);
    cycles(D + 3);
    check("R8 in pulse", alt_rst_n, 0);
    wr(A, 8'h00);
    check("R8 before abort edge", alt_rst_n, 0);
    @(negedge clk);
    check("R8 aborted", alt_rst_n, 1);
    wr(A, 8'h01);
    cycles(D - 5);
    wr(A, 8'h00);
    all_high = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!alt_rst_n) all_high = 0; end
    check("R8 abort in delay", all_high, 1);
    wr(A, 8'h01);
    measure(dly, wid);
    check("R8 restart delay", dly, D + 1);
    wr(A, 8'h00);

    port_en = 0;
    wr(A, 8'h01);
    all_high = 1;
    for (int i = 0; i < D + P + 5; i++) begin @(negedge clk); if (!alt_rst_n) all_high = 0; end
    check("R2 no pulse disabled", all_high, 1);
    port_en = 1;

    kbc_rst_n = 0;
    cycles(2);
    check("R9 kbc reset pol0", sys_rst_out, 0);
    rst_polarity = 1;
    cycles(2);
    check("R9 kbc reset pol1", sys_rst_out, 1);
    kbc_rst_n = 1;
    cycles(2);
    check("R9 idle pol1", sys_rst_out, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule